// File: doc/BRIEF.md
# Register Producer Map with Rollback History

This block keeps, for every architectural register, the identity of the function unit that will deliver that register's newest value. Issue logic writes an entry when an instruction claims a register as its destination. Operand-read logic looks an entry up by register index to learn whether the value is still in flight and, if so, which unit will supply it. The table is addressed directly by index and is never searched.

When a newer instruction claims a register, the unit it displaces is not forgotten. The displaced identity goes onto a small per-register history stack. If the newer instruction is later killed by an exception, its entry falls back to the displaced unit, which becomes a named producer again. When a unit finishes and its result reaches the register file, a commit removes that unit from every history stack. If the unit is still the current producer of a register, that register's entry becomes invalid, which means the register file holds the value.

Rollback, commit and issue may all arrive in the same cycle. Each register applies them in that order. When a register's history stack is full, an issue aimed at it is refused, and the block raises a stall output.

Top module: `reg_producer_map`

## Requirements
- R1: After reset every register entry reads as invalid, and the full output is low.
- R2: The lookup port gives the valid flag and the current producer unit of the register on `lk_reg_i` combinationally. An accepted issue is visible there from the cycle after the issue edge.
- R3: An issue to an invalid entry makes it valid with the new unit and records no history. A rollback of that unit then returns the entry to invalid.
- R4: An issue to a valid entry pushes the old producer onto that register's history. A rollback of the new unit makes the old producer current again.
- R5: A rollback of a unit makes every entry whose current producer is that unit pop its history, or become invalid if its history is empty.
- R6: A single rollback acts on all registers that name the killed unit, and leaves entries naming other units unchanged.
- R7: A commit of a unit that is the current producer of a register makes that entry invalid and empties its history.
- R8: A commit of a unit that sits in a register's history removes it from that history without changing the current producer. A later rollback then restores the next older producer.
- R9: When the entry for `iss_reg_i` already holds a valid producer plus 4 history items, `iss_full_o` is high and an issue to that register is ignored. Otherwise `iss_full_o` is low.
- R10: Within one cycle a register applies rollback first, then commit, then issue. The issued unit is therefore current after the edge even when it is committed in that same cycle, and a rollback in that cycle only restores the history beneath it.
- R11: Operations in the same cycle that touch different registers each take effect independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_reg_i | input | 3 | Register index to look up |
| lk_valid_o | output | 1 | Looked-up register has a pending producer |
| lk_unit_o | output | 3 | Current producer unit of the looked-up register |
| iss_en_i | input | 1 | Issue request |
| iss_reg_i | input | 3 | Destination register of the issue |
| iss_unit_i | input | 3 | Unit claiming the destination |
| iss_full_o | output | 1 | History of `iss_reg_i` is full; issue must stall |
| cmt_en_i | input | 1 | Commit request |
| cmt_unit_i | input | 3 | Unit whose result reached the register file |
| rb_en_i | input | 1 | Rollback request |
| rb_unit_i | input | 3 | Unit killed by an exception |

## Verification
Two pairs of functions are driven into the same clock edge. In the first pair, a rollback of a register's current producer coincides with an issue to that same register. In the second pair, a commit of a unit coincides with an issue that names that unit as the new producer. Each register applies rollback, then commit, then issue, so in both cases the issuer must be current after the edge. A follow-up rollback then shows that no stale history was left beneath it. A further edge combines a rollback, a commit and an issue on three different registers. The bench checks each of the three entries through the lookup port.

// File: rtl/reg_producer_map.sv
module reg_producer_map #(
  parameter int NREG   = 8,
  parameter int NUNIT  = 8,
  parameter int HDEPTH = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [$clog2(NREG)-1:0]   lk_reg_i,
  output logic                      lk_valid_o,
  output logic [$clog2(NUNIT)-1:0]  lk_unit_o,
  input  logic                      iss_en_i,
  input  logic [$clog2(NREG)-1:0]   iss_reg_i,
  input  logic [$clog2(NUNIT)-1:0]  iss_unit_i,
  output logic                      iss_full_o,
  input  logic                      cmt_en_i,
  input  logic [$clog2(NUNIT)-1:0]  cmt_unit_i,
  input  logic                      rb_en_i,
  input  logic [$clog2(NUNIT)-1:0]  rb_unit_i
);
  localparam int RW = $clog2(NREG);
  localparam int UW = $clog2(NUNIT);
  localparam int CW = $clog2(HDEPTH + 1);
  localparam int HW = (HDEPTH > 1) ? $clog2(HDEPTH) : 1;

  logic [NREG-1:0] vld_q, vld_d;
  logic [UW-1:0]   cur_q  [NREG];
  logic [UW-1:0]   cur_d  [NREG];
  logic [CW-1:0]   cnt_q  [NREG];
  logic [CW-1:0]   cnt_d  [NREG];
  logic [UW-1:0]   hist_q [NREG][HDEPTH];
  logic [UW-1:0]   hist_d [NREG][HDEPTH];

  logic iss_ok;

  assign lk_valid_o = vld_q[lk_reg_i];
  assign lk_unit_o  = cur_q[lk_reg_i];
  assign iss_full_o = (cnt_q[iss_reg_i] == CW'(HDEPTH));
  assign iss_ok     = iss_en_i && !iss_full_o;

  always_comb begin
    logic          v;
    logic [UW-1:0] c;
    logic [CW-1:0] n, nm1, k;
    logic [UW-1:0] h  [HDEPTH];
    logic [UW-1:0] hk [HDEPTH];
    for (int r = 0; r < NREG; r++) begin
      v   = vld_q[r];
      c   = cur_q[r];
      n   = cnt_q[r];
      h   = hist_q[r];
      hk  = hist_q[r];
      nm1 = n - 1'b1;
      k   = '0;

      if (rb_en_i && v && c == rb_unit_i) begin
        if (n != '0) begin
          c = h[nm1[HW-1:0]];
          n = nm1;
        end else begin
          v = 1'b0;
        end
      end

      if (cmt_en_i) begin
        if (v && c == cmt_unit_i) begin
          v = 1'b0;
          n = '0;
        end else begin
          for (int i = 0; i < HDEPTH; i++) begin
            if (CW'(i) < n && h[i] != cmt_unit_i) begin
              hk[k[HW-1:0]] = h[i];
              k = k + 1'b1;
            end
          end
          h = hk;
          n = k;
        end
      end

      if (iss_ok && iss_reg_i == RW'(r)) begin
        if (v) begin
          h[n[HW-1:0]] = c;
          n = n + 1'b1;
        end
        c = iss_unit_i;
        v = 1'b1;
      end

      vld_d[r]  = v;
      cur_d[r]  = c;
      cnt_d[r]  = n;
      hist_d[r] = h;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int r = 0; r < NREG; r++) begin
        cur_q[r] <= '0;
        cnt_q[r] <= '0;
        for (int i = 0; i < HDEPTH; i++) hist_q[r][i] <= '0;
      end
    end else begin
      vld_q  <= vld_d;
      cur_q  <= cur_d;
      cnt_q  <= cnt_d;
      hist_q <= hist_d;
    end
  end
endmodule

module reg_producer_map_chk #(
  parameter int NREG  = 8,
  parameter int NUNIT = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [$clog2(NREG)-1:0]  lk_reg_i,
  input logic                     lk_valid_o,
  input logic [$clog2(NUNIT)-1:0] lk_unit_o,
  input logic                     iss_en_i,
  input logic [$clog2(NREG)-1:0]  iss_reg_i,
  input logic [$clog2(NUNIT)-1:0] iss_unit_i,
  input logic                     iss_full_o,
  input logic                     cmt_en_i,
  input logic [$clog2(NUNIT)-1:0] cmt_unit_i,
  input logic                     rb_en_i,
  input logic [$clog2(NUNIT)-1:0] rb_unit_i
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !lk_valid_o);

  p_issue_visible_r2_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(iss_en_i && !iss_full_o) && lk_reg_i == $past(iss_reg_i))
      |-> (lk_valid_o && lk_unit_o == $past(iss_unit_i)));

  p_rollback_gone_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rb_en_i && !iss_en_i) |-> !(lk_valid_o && lk_unit_o == $past(rb_unit_i)));

  p_commit_gone_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmt_en_i && !iss_en_i) |-> !(lk_valid_o && lk_unit_o == $past(cmt_unit_i)));

  p_full_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_full_o && lk_reg_i == iss_reg_i) |-> lk_valid_o);

  p_full_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(iss_en_i && iss_full_o && !rb_en_i && !cmt_en_i) && $stable(lk_reg_i)
       && lk_reg_i == $past(iss_reg_i))
      |-> (lk_valid_o && $stable(lk_unit_o)));
endmodule

bind reg_producer_map reg_producer_map_chk #(.NREG(NREG), .NUNIT(NUNIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_reg_i(lk_reg_i), .lk_valid_o(lk_valid_o),
  .lk_unit_o(lk_unit_o), .iss_en_i(iss_en_i), .iss_reg_i(iss_reg_i),
  .iss_unit_i(iss_unit_i), .iss_full_o(iss_full_o), .cmt_en_i(cmt_en_i),
  .cmt_unit_i(cmt_unit_i), .rb_en_i(rb_en_i), .rb_unit_i(rb_unit_i)
);

// File: tb/reg_producer_map_bench.sv
module reg_producer_map_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] lk_reg_i = '0;
  logic       lk_valid_o;
  logic [2:0] lk_unit_o;
  logic       iss_en_i = 1'b0;
  logic [2:0] iss_reg_i = '0;
  logic [2:0] iss_unit_i = '0;
  logic       iss_full_o;
  logic       cmt_en_i = 1'b0;
  logic [2:0] cmt_unit_i = '0;
  logic       rb_en_i = 1'b0;
  logic [2:0] rb_unit_i = '0;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    bit    is_full;
    int    rg;
    bit    v;
    int    u;
    string tag;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  reg_producer_map u_reg_producer_map (
    .clk(clk), .rst_n(rst_n), .lk_reg_i(lk_reg_i), .lk_valid_o(lk_valid_o),
    .lk_unit_o(lk_unit_o), .iss_en_i(iss_en_i), .iss_reg_i(iss_reg_i),
    .iss_unit_i(iss_unit_i), .iss_full_o(iss_full_o), .cmt_en_i(cmt_en_i),
    .cmt_unit_i(cmt_unit_i), .rb_en_i(rb_en_i), .rb_unit_i(rb_unit_i)
  );

  initial begin
    forever begin
      #1;
      if (q.size() != 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (it.is_full) begin
          if (iss_full_o !== it.v) begin
            failures++;
            $display("FAIL %s full reg %0d: actual %0b expected %0b", it.tag, iss_reg_i, iss_full_o, it.v);
          end
        end else begin
          lk_reg_i = 3'(it.rg);
          #1;
          if (lk_valid_o !== it.v || (it.v && lk_unit_o !== 3'(it.u))) begin
            failures++;
            $display("FAIL %s reg %0d: actual v=%0b u=%0d expected v=%0b u=%0d",
                     it.tag, it.rg, lk_valid_o, lk_unit_o, it.v, it.u);
          end
        end
      end
    end
  end

  task automatic expect_lk(int rg, bit v, int u, string tag);
    item_t it;
    it.is_full = 0; it.rg = rg; it.v = v; it.u = u; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic expect_full(int rg, bit f, string tag);
    item_t it;
    while (q.size() != 0) #1;
    iss_reg_i = 3'(rg);
    it.is_full = 1; it.rg = rg; it.v = f; it.u = 0; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic drain();
    while (q.size() != 0) #1;
    #2;
  endtask

  task automatic op(bit rb, int rbu, bit cm, int cmu, bit is, int isr, int isu);
    drain();
    @(negedge clk);
    rb_en_i = rb;  rb_unit_i  = 3'(rbu);
    cmt_en_i = cm; cmt_unit_i = 3'(cmu);
    iss_en_i = is; iss_reg_i  = 3'(isr); iss_unit_i = 3'(isu);
    @(posedge clk);
    #1;
    rb_en_i = 0; cmt_en_i = 0; iss_en_i = 0;
  endtask

  task automatic issue(int r, int u);  op(0, 0, 0, 0, 1, r, u); endtask
  task automatic kill(int u);          op(1, u, 0, 0, 0, 0, 0); endtask
  task automatic retire(int u);        op(0, 0, 1, u, 0, 0, 0); endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    expect_lk(0, 0, 0, "R1");
    expect_lk(3, 0, 0, "R1");
    expect_lk(7, 0, 0, "R1");
    expect_full(0, 0, "R1");

    // R2 R3: issue to empty entry, then rollback
    issue(1, 2);
    expect_lk(1, 1, 2, "R2");
    kill(2);
    expect_lk(1, 0, 0, "R3");

    // R4: push and restore
    issue(1, 2);
    issue(1, 3);
    expect_lk(1, 1, 3, "R4");
    kill(3);
    expect_lk(1, 1, 2, "R4");
    kill(2);
    expect_lk(1, 0, 0, "R5");

    // R5 R6: one rollback, several registers
    issue(2, 1);
    issue(2, 4);
    issue(5, 4);
    issue(3, 6);
    kill(4);
    expect_lk(2, 1, 1, "R6");
    expect_lk(5, 0, 0, "R5");
    expect_lk(3, 1, 6, "R6");
    retire(1);
    expect_lk(2, 0, 0, "R7");
    retire(6);
    expect_lk(3, 0, 0, "R7");

    // R8: commit from history
    issue(3, 1);
    issue(3, 2);
    issue(3, 3);
    retire(2);
    expect_lk(3, 1, 3, "R8");
    kill(3);
    expect_lk(3, 1, 1, "R8");
    retire(1);
    expect_lk(3, 0, 0, "R7");

    // R9: full history
    for (int u = 0; u < 5; u++) issue(4, u);
    expect_lk(4, 1, 4, "R9");
    expect_full(4, 1, "R9");
    expect_full(5, 0, "R9");
    issue(4, 5);
    expect_lk(4, 1, 4, "R9");
    kill(4);
    expect_lk(4, 1, 3, "R9");
    expect_full(4, 0, "R9");
    retire(3);
    expect_lk(4, 0, 0, "R7");
    issue(4, 6);
    kill(6);
    expect_lk(4, 0, 0, "R7");

    // R10: same-cycle ordering
    issue(6, 1);
    op(1, 1, 0, 0, 1, 6, 2);
    expect_lk(6, 1, 2, "R10");
    kill(2);
    expect_lk(6, 0, 0, "R10");
    issue(6, 3);
    op(0, 0, 1, 5, 1, 6, 5);
    expect_lk(6, 1, 5, "R10");
    kill(5);
    expect_lk(6, 1, 3, "R10");
    retire(3);
    expect_lk(6, 0, 0, "R10");

    // R11: independent registers in one cycle
    issue(7, 0);
    issue(7, 6);
    issue(1, 1);
    op(1, 6, 1, 1, 1, 0, 7);
    expect_lk(7, 1, 0, "R11");
    expect_lk(1, 0, 0, "R11");
    expect_lk(0, 1, 7, "R11");
    drain();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule